// File: doc/BRIEF.md
# Serial Channel Register Front End

This block is the register face of a character-oriented serial channel. A simple single-cycle bus slave selects one of seven 32-bit word registers by byte offset. The registers are status, data, baud setting, three control words and a guard/prescale word. Writes to the data register leave the block as a one-clock byte strobe toward a transmitter. Bytes arriving from a receiver over a valid/ready handshake are latched into the data register.

The block does no serialization of its own. The baud, second and third control words and the guard word are plain storage for downstream logic. The status register carries three flags that change as side effects of bus reads and writes, as well as of receive events:

- transmit-empty (bit 7)
- transmit-complete (bit 6)
- receive-not-empty (bit 5)

The first control word gates reception and can arm a sticky level interrupt.

Top module: `serial_front`

## Requirements
- R1: After reset, status reads 0x00C00000, every other register reads 0, and `irq`, `rxReady`, `txValid` and `busErr` are low.
- R2: Word offsets 0x08 (baud), 0x0C (control one), 0x10 (control two), 0x14 (control three) and 0x18 (guard) each store a full 32-bit write and return it on read.
- R3: A status read (offset 0x00) returns the current status in the same cycle. From the next cycle, bit 6 and bits 31..16 of status are cleared.
- R4: A data read (offset 0x04) returns the data register zero-extended from its low 10 bits, and sets status bit 7.
- R5: A status write of a value at most 0x3FF replaces status. A larger value is ANDed into the current status.
- R6: A data write of a value below 0xF000 raises `txValid` for exactly the next cycle, with `txByte` equal to the low 8 bits, and sets status bit 6. The data register itself is left unchanged.
- R7: A data write of 0xF000 or more produces no `txValid` and leaves status unchanged.
- R8: `rxReady` is high exactly when control-one bits 13 and 3 are both set. A byte offered while it is high is stored in the data register and sets status bit 5.
- R9: A byte offered while `rxReady` is low changes neither the data register nor status.
- R10: An accepted byte raises `irq` if control-one bit 5 is set. Once high, `irq` stays high until reset, whatever is written.
- R11: Any other offset, including misaligned ones, reads 0, and writing it changes no register. Such an access pulses `busErr` for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one access per high cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the access cycle |
| busErr | output | 1 | One-cycle pulse after an undefined-offset access |
| txValid | output | 1 | Outbound byte strobe |
| txByte | output | BYTE_W | Outbound byte |
| rxValid | input | 1 | Inbound byte offered |
| rxByte | input | BYTE_W | Inbound byte |
| rxReady | output | 1 | Inbound bytes accepted |
| irq | output | 1 | Sticky receive interrupt level |

## Verification
Some behaviour is checked on every cycle. This covers:

- the transmit strobe following each accepted data write with the right byte
- the strobe never appearing otherwise, including for oversized data writes
- `rxReady` tracking the last control-one write
- the interrupt being sticky and rising only after an accepted byte
- the error pulse and zero read data on undefined offsets

The flag side effects can only be shown by the bench's access sequences. These include read-clears, the replace-versus-AND status write, receive gating and the data-register contents, since they appear only through later reads.

// File: rtl/serial_front_pkg.sv
package serial_front_pkg;

  // Byte offsets of the word registers.
  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_DATA   = 8'h04;
  localparam logic [7:0] OFF_BAUD   = 8'h08;
  localparam logic [7:0] OFF_CTRL1  = 8'h0C;
  localparam logic [7:0] OFF_CTRL2  = 8'h10;
  localparam logic [7:0] OFF_CTRL3  = 8'h14;
  localparam logic [7:0] OFF_GUARD  = 8'h18;

  // Status flag positions.
  localparam int BIT_TXE  = 7;
  localparam int BIT_TC   = 6;
  localparam int BIT_RXNE = 5;

  // Control-one bit positions.
  localparam int BIT_EN   = 13;
  localparam int BIT_RXIE = 5;
  localparam int BIT_TXEN = 3;

  localparam logic [31:0] STATUS_RST  = 32'h00C0_0000;
  localparam logic [31:0] REPLACE_MAX = 32'h0000_03FF;
  localparam logic [31:0] TX_LIMIT    = 32'h0000_F000;

  typedef enum logic [2:0] {
    SEL_STATUS, SEL_DATA, SEL_BAUD, SEL_CTRL1,
    SEL_CTRL2, SEL_CTRL3, SEL_GUARD, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    rd;
    logic    wr;
    logic    bad;
    regSel_e sel;
  } busStrobe_t;

endpackage

// File: rtl/serial_front_ctrl.sv
module serial_front_ctrl
  import serial_front_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  regSel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if      (busAddr == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
    else if (busAddr == ADDR_W'(OFF_DATA))   sel = SEL_DATA;
    else if (busAddr == ADDR_W'(OFF_BAUD))   sel = SEL_BAUD;
    else if (busAddr == ADDR_W'(OFF_CTRL1))  sel = SEL_CTRL1;
    else if (busAddr == ADDR_W'(OFF_CTRL2))  sel = SEL_CTRL2;
    else if (busAddr == ADDR_W'(OFF_CTRL3))  sel = SEL_CTRL3;
    else if (busAddr == ADDR_W'(OFF_GUARD))  sel = SEL_GUARD;
  end

  always_comb begin
    strobe.rd  = busSel & ~busWrite;
    strobe.wr  = busSel & busWrite;
    strobe.bad = busSel & (sel == SEL_NONE);
    strobe.sel = sel;
  end

endmodule

// File: rtl/serial_front_dp.sv
module serial_front_dp
  import serial_front_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int RD_KEEP_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              rxReady,
  output logic              irq,
  output logic              busErr
);

  localparam int CFG_N = 4;  // baud, ctrl2, ctrl3, guard
  localparam logic [DATA_W-1:0] LOW_HALF =
    {{(DATA_W - DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};

  logic [DATA_W-1:0]    statusReg, statusNext, ctrl1Reg;
  logic [RD_KEEP_W-1:0] dataReg;
  logic [DATA_W-1:0]    cfgView [CFG_N];
  logic [CFG_N-1:0]     cfgWe;
  logic                 rxTake, txTake, stRead, stWrite, dtRead;

  assign rxReady = ctrl1Reg[BIT_EN] & ctrl1Reg[BIT_TXEN];
  assign rxTake  = rxValid & rxReady;
  assign stRead  = strobe.rd & (strobe.sel == SEL_STATUS);
  assign stWrite = strobe.wr & (strobe.sel == SEL_STATUS);
  assign dtRead  = strobe.rd & (strobe.sel == SEL_DATA);
  assign txTake  = strobe.wr & (strobe.sel == SEL_DATA) &
                   (busWdata < DATA_W'(TX_LIMIT));

  assign cfgWe = {strobe.wr & (strobe.sel == SEL_GUARD),
                  strobe.wr & (strobe.sel == SEL_CTRL3),
                  strobe.wr & (strobe.sel == SEL_CTRL2),
                  strobe.wr & (strobe.sel == SEL_BAUD)};

  // Storage-only words share one register template.
  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)         q <= '0;
      else if (cfgWe[g]) q <= busWdata;
    end
    assign cfgView[g] = q;
  end

  // Status flag side effects; a bus access and a receive may coincide.
  always_comb begin
    statusNext = statusReg;
    if (stRead) begin
      statusNext         = statusNext & LOW_HALF;
      statusNext[BIT_TC] = 1'b0;
    end
    if (dtRead) statusNext[BIT_TXE] = 1'b1;
    if (stWrite) begin
      if (busWdata <= DATA_W'(REPLACE_MAX)) statusNext = busWdata;
      else                                 statusNext = statusReg & busWdata;
    end
    if (txTake) statusNext[BIT_TC]   = 1'b1;
    if (rxTake) statusNext[BIT_RXNE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= DATA_W'(STATUS_RST);
      dataReg   <= '0;
      ctrl1Reg  <= '0;
      irq       <= 1'b0;
      txValid   <= 1'b0;
      txByte    <= '0;
      busErr    <= 1'b0;
    end else begin
      statusReg <= statusNext;
      if (rxTake) dataReg <= RD_KEEP_W'(rxByte);
      if (strobe.wr && strobe.sel == SEL_CTRL1) ctrl1Reg <= busWdata;
      if (rxTake && ctrl1Reg[BIT_RXIE]) irq <= 1'b1;
      txValid <= txTake;
      if (txTake) txByte <= busWdata[BYTE_W-1:0];
      busErr  <= strobe.bad;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobe.rd) begin
      case (strobe.sel)
        SEL_STATUS: busRdata = statusReg;
        SEL_DATA:   busRdata = DATA_W'(dataReg);
        SEL_BAUD:   busRdata = cfgView[0];
        SEL_CTRL1:  busRdata = ctrl1Reg;
        SEL_CTRL2:  busRdata = cfgView[1];
        SEL_CTRL3:  busRdata = cfgView[2];
        SEL_GUARD:  busRdata = cfgView[3];
        default:    busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/serial_front.sv
module serial_front
  import serial_front_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int RD_KEEP_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              rxReady,
  output logic              irq
);

  busStrobe_t strobe;

  serial_front_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  serial_front_dp #(
    .DATA_W    (DATA_W),
    .BYTE_W    (BYTE_W),
    .RD_KEEP_W (RD_KEEP_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .busRdata (busRdata),
    .txValid  (txValid),
    .txByte   (txByte),
    .rxReady  (rxReady),
    .irq      (irq),
    .busErr   (busErr)
  );

endmodule

// File: rtl/serial_front_chk.sv
module serial_front_chk
  import serial_front_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busErr,
  input logic              txValid,
  input logic [BYTE_W-1:0] txByte,
  input logic              rxValid,
  input logic              rxReady,
  input logic              irq
);

  logic known, dataWr, ctrl1Wr, undefAcc;

  assign known = (busAddr == ADDR_W'(OFF_STATUS)) || (busAddr == ADDR_W'(OFF_DATA)) ||
                 (busAddr == ADDR_W'(OFF_BAUD))   || (busAddr == ADDR_W'(OFF_CTRL1)) ||
                 (busAddr == ADDR_W'(OFF_CTRL2))  || (busAddr == ADDR_W'(OFF_CTRL3)) ||
                 (busAddr == ADDR_W'(OFF_GUARD));
  assign dataWr   = busSel && busWrite && (busAddr == ADDR_W'(OFF_DATA));
  assign ctrl1Wr  = busSel && busWrite && (busAddr == ADDR_W'(OFF_CTRL1));
  assign undefAcc = busSel && !known;

  p_tx_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && busWdata < DATA_W'(TX_LIMIT)) |=>
      (txValid && txByte == $past(busWdata[BYTE_W-1:0])));

  p_tx_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && busWdata >= DATA_W'(TX_LIMIT)) |=> !txValid);

  p_tx_only_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dataWr |=> !txValid);

  p_ready_ctrl_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl1Wr |=> (rxReady == ($past(busWdata[BIT_EN]) && $past(busWdata[BIT_TXEN]))));

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> irq);

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(rxValid && rxReady));

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    undefAcc |=> busErr);

  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !undefAcc |=> !busErr);

  p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (undefAcc && !busWrite) |-> (busRdata == '0));

endmodule

bind serial_front serial_front_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .busErr   (busErr),
  .txValid  (txValid),
  .txByte   (txByte),
  .rxValid  (rxValid),
  .rxReady  (rxReady),
  .irq      (irq)
);

// File: tb/serial_front_tb.sv
module serial_front_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr, txValid, rxReady, irq;
  logic [7:0]  txByte;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;  // 125 MHz

  serial_front u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .txValid(txValid), .txByte(txByte),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady), .irq(irq)
  );

  typedef struct packed {
    logic        isWr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expRd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,        32'h00C0_0000, 4'd1},  // R1 status reset value
    '{1'b0, 8'h00, 32'h0,        32'h0000_0000, 4'd3},  // R3 upper half cleared
    '{1'b1, 8'h08, 32'h1234_ABCD, 32'h0,        4'd2},
    '{1'b0, 8'h08, 32'h0,        32'h1234_ABCD, 4'd2},  // R2 baud
    '{1'b1, 8'h10, 32'hA5A5_0001, 32'h0,        4'd2},
    '{1'b0, 8'h10, 32'h0,        32'hA5A5_0001, 4'd2},  // R2 ctrl2
    '{1'b1, 8'h14, 32'h0000_0F0F, 32'h0,        4'd2},
    '{1'b0, 8'h14, 32'h0,        32'h0000_0F0F, 4'd2},  // R2 ctrl3
    '{1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0,        4'd2},
    '{1'b0, 8'h18, 32'h0,        32'hFFFF_FFFF, 4'd2},  // R2 guard
    '{1'b0, 8'h0C, 32'h0,        32'h0,         4'd1},  // R1 ctrl1 reset
    '{1'b0, 8'h04, 32'h0,        32'h0,         4'd4},  // R4 data read
    '{1'b0, 8'h00, 32'h0,        32'h0000_0080, 4'd4},  // R4 transmit-empty set
    '{1'b1, 8'h04, 32'h0000_0141, 32'h0,        4'd6},
    '{1'b0, 8'h00, 32'h0,        32'h0000_00C0, 4'd6},  // R6 transmit-complete set
    '{1'b0, 8'h00, 32'h0,        32'h0000_0080, 4'd3},  // R3 read cleared it
    '{1'b1, 8'h04, 32'h0000_F000, 32'h0,        4'd7},
    '{1'b0, 8'h00, 32'h0,        32'h0000_0080, 4'd7},  // R7 no flag change
    '{1'b1, 8'h00, 32'h0000_03FF, 32'h0,        4'd5},
    '{1'b0, 8'h00, 32'h0,        32'h0000_03FF, 4'd5},  // R5 replace
    '{1'b0, 8'h00, 32'h0,        32'h0000_03BF, 4'd3},
    '{1'b1, 8'h00, 32'hFFFF_FF0F, 32'h0,        4'd5},
    '{1'b0, 8'h00, 32'h0,        32'h0000_030F, 4'd5},  // R5 AND
    '{1'b1, 8'h00, 32'h0000_0400, 32'h0,        4'd5},
    '{1'b0, 8'h00, 32'h0,        32'h0000_0000, 4'd5},
    '{1'b1, 8'h1C, 32'hDEAD_BEEF, 32'h0,        4'd11},
    '{1'b0, 8'h1C, 32'h0,        32'h0,         4'd11}, // R11 undefined reads 0
    '{1'b1, 8'h0D, 32'h0000_FFFF, 32'h0,        4'd11},
    '{1'b0, 8'h0C, 32'h0,        32'h0,         4'd11}, // R11 misaligned write ignored
    '{1'b0, 8'h02, 32'h0,        32'h0,         4'd11},
    '{1'b0, 8'h08, 32'h0,        32'h1234_ABCD, 4'd11},
    '{1'b0, 8'h04, 32'h0,        32'h0,         4'd6}   // R6 data register untouched
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busAcc(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic txV,
                        output logic [7:0] txB, output logic err);
    @(negedge clk);
    busSel = 1'b1; busWrite = w; busAddr = a; busWdata = d;
    #2 rd = busRdata;
    @(posedge clk);
    #1 txV = txValid; txB = txByte; err = busErr;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(posedge clk);
    #1 rxValid = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    logic        tv, er;
    logic [7:0]  tb;
    doReset();
    // R1 port state after reset
    #1;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rxReady", {31'b0, rxReady}, 32'h0);
    chk("R1 txValid", {31'b0, txValid}, 32'h0);
    chk("R1 busErr", {31'b0, busErr}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      busAcc(VECS[i].isWr, VECS[i].addr, VECS[i].wdata, rd, tv, tb, er);
      if (!VECS[i].isWr) chk($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].expRd);
    end

    // R6 one-cycle outbound strobe carrying the low byte
    busAcc(1'b1, 8'h04, 32'h0000_01A5, rd, tv, tb, er);
    chk("R6 txValid", {31'b0, tv}, 32'h1);
    chk("R6 txByte", {24'b0, tb}, 32'h0000_00A5);
    @(posedge clk); #1;
    chk("R6 txValid drop", {31'b0, txValid}, 32'h0);
    // R7 oversized data write
    busAcc(1'b1, 8'h04, 32'h0000_F123, rd, tv, tb, er);
    chk("R7 txValid", {31'b0, tv}, 32'h0);
    // R11 error pulse
    busAcc(1'b0, 8'h20, 32'h0, rd, tv, tb, er);
    chk("R11 busErr undefined", {31'b0, er}, 32'h1);
    busAcc(1'b0, 8'h08, 32'h0, rd, tv, tb, er);
    chk("R11 busErr defined", {31'b0, er}, 32'h0);

    // R9 byte ignored while not ready
    chk("R8 ready low", {31'b0, rxReady}, 32'h0);
    sendByte(8'h55);
    busAcc(1'b0, 8'h04, 32'h0, rd, tv, tb, er);
    chk("R9 data unchanged", rd, 32'h0);
    busAcc(1'b0, 8'h00, 32'h0, rd, tv, tb, er);
    chk("R9 rxne clear", {31'b0, rd[5]}, 32'h0);

    // R8 enabled receive
    busAcc(1'b1, 8'h0C, 32'h0000_2008, rd, tv, tb, er);
    #1 chk("R8 ready high", {31'b0, rxReady}, 32'h1);
    sendByte(8'h3C);
    busAcc(1'b0, 8'h00, 32'h0, rd, tv, tb, er);
    chk("R8 rxne set", {31'b0, rd[5]}, 32'h1);
    busAcc(1'b0, 8'h04, 32'h0, rd, tv, tb, er);
    chk("R8 data stored", rd, 32'h0000_003C);
    chk("R10 no irq without enable", {31'b0, irq}, 32'h0);
    busAcc(1'b1, 8'h0C, 32'h0000_2000, rd, tv, tb, er);
    #1 chk("R8 ready needs both bits", {31'b0, rxReady}, 32'h0);

    // R10 interrupt raise and stickiness
    busAcc(1'b1, 8'h0C, 32'h0000_2028, rd, tv, tb, er);
    sendByte(8'h7E);
    #1 chk("R10 irq raised", {31'b0, irq}, 32'h1);
    busAcc(1'b1, 8'h0C, 32'h0, rd, tv, tb, er);
    busAcc(1'b1, 8'h00, 32'h0, rd, tv, tb, er);
    chk("R10 irq sticky", {31'b0, irq}, 32'h1);
    busAcc(1'b0, 8'h04, 32'h0, rd, tv, tb, er);
    chk("R8 second byte", rd, 32'h0000_007E);

    // R1 reset again
    doReset();
    #1 chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    busAcc(1'b0, 8'h00, 32'h0, rd, tv, tb, er);
    chk("R1 status", rd, 32'h00C0_0000);
    busAcc(1'b0, 8'h18, 32'h0, rd, tv, tb, er);
    chk("R1 guard", rd, 32'h0);

    done = 1;
    finishRun();
  end

endmodule